// File: doc/BRIEF.md
# Prescaled Interrupt Countdown Timer

This block is the countdown timer found next to a processor's local interrupt controller. Software programs three registers: a start value, a clock divider and a timer entry. The timer entry holds an interrupt vector, a mask bit and a repeat-mode bit. The counter then steps down once per prescaled tick. When an expiry is reached and the timer entry is not masked, the block raises a single-cycle interrupt request that carries the programmed vector.

In one-shot mode the counter stops at zero and the block requests once. In repeat mode the counter reloads the start value one tick after reaching zero, so one period lasts the start value plus one ticks. A write port loads the registers. A combinational read port returns any of the three registers or the live count. Prioritising the request against other sources and delivering it elsewhere are left to the surrounding logic.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the start value, the divider and the live count read as zero, the timer entry reads 0x00010000 (masked, one-shot, vector 0), and no request is raised.
- R2: A divider write keeps only bits 3, 1 and 0 (it is ANDed with 0xB). With v = {bit3, bit1, bit0}, the count steps once every 2^((v+1) mod 8) clock cycles. 0xB gives a step every cycle, 0x1 every 4 cycles, 0x3 every 16 cycles and 0x8 every 32 cycles.
- R3: A divider change made while the prescaler is mid-interval takes effect only after the interval in progress ends with its tick.
- R4: In one-shot mode with start value N > 0, the count reads N-k after k ticks and then holds at zero. Exactly one request is raised, in the cycle after the (N+1)th tick edge.
- R5: In repeat mode with start value N > 0, the count reloads to N on the tick that follows zero. A request is raised on every such reload, so requests arrive every N+1 ticks.
- R6: A start value of zero never produces a request, in either mode.
- R7: A start-value write (select 0) places the written value in the count on the next cycle and restarts the prescaler. It rearms a one-shot expiry. If it coincides with an expiry tick, that expiry is dropped.
- R8: While timer-entry bit 16 (mask) is set, no request is raised but counting continues. A one-shot expiry that passes while masked is not raised later when the mask is cleared. A repeat-mode timer requests again at its next reload after the mask is cleared.
- R9: Timer-entry bit 17 selects repeat mode (1) or one-shot mode (0), bit 16 is the mask and bits 7:0 are the vector. All other bits read as zero. The request's vector output equals the programmed vector in the request cycle.
- R10: Read select 0 returns the start value, 1 the divider, 2 the timer entry and 3 the live count. A write with select 3 changes nothing.
- R11: The request output is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 start value, 1 divider, 2 timer entry, 3 none |
| wrData | input | CNT_W | Write data |
| rdSel | input | 2 | Read target: 0 start value, 1 divider, 2 timer entry, 3 live count |
| rdData | output | CNT_W | Read data, combinational |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | VEC_W | Vector that goes with the request |

## Verification
The tick that would expire the counter can land in the same cycle as a start-value write. The bench provokes this with a one-shot run at divide-by-one: it writes a new start value in exactly the cycle where the count has just reached zero and the next tick would fire. It then judges that no request appears in the following cycle. The live count must show the new value, and the single request must arrive only after the restarted run of new-value-plus-one ticks. A second collision pairs a divider write with a prescaler interval already in flight. The count must keep the old step spacing for that interval and switch to the new one after it.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // divider field is three bits wide once compressed
  localparam int DIV_W        = 3;
  localparam int LVT_PER_BIT  = 17;
  localparam int LVT_MASK_BIT = 16;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_LVT  = 2'd2,
    SEL_CUR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic restart;  // load count from write data, restart prescaler
    logic dec;      // step count down by one
    logic reload;   // repeat-mode reload from start value
  } cdtStrb_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             tick,
  input  logic             cntZero,
  output cdtStrb_t         strb,
  output logic [CNT_W-1:0] initVal,
  output logic [3:0]       divReg,
  output logic [DIV_W-1:0] divShift,
  output logic [VEC_W-1:0] lvtVec,
  output logic             lvtMask,
  output logic             lvtPeriodic,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  logic ldInit, ldDiv, ldLvt, armed, expire;

  assign ldInit = wrEn && (regSel_e'(wrSel) == SEL_INIT);
  assign ldDiv  = wrEn && (regSel_e'(wrSel) == SEL_DIV);
  assign ldLvt  = wrEn && (regSel_e'(wrSel) == SEL_LVT);

  // compressed divider code plus one, wrapping in three bits
  assign divShift = {divReg[3], divReg[1:0]} + DIV_W'(1);

  // a start-value write in the same cycle wins over an expiry
  assign expire = tick && cntZero && !ldInit &&
                  (lvtPeriodic ? (initVal != '0) : armed);

  always_comb begin
    strb.restart = ldInit;
    strb.dec     = tick && !cntZero && !ldInit;
    strb.reload  = expire && lvtPeriodic;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initVal     <= '0;
      divReg      <= '0;
      lvtVec      <= '0;
      lvtMask     <= 1'b1;
      lvtPeriodic <= 1'b0;
      armed       <= 1'b0;
      irqValid    <= 1'b0;
      irqVector   <= '0;
    end else begin
      if (ldInit) initVal <= wrData;
      if (ldDiv)  divReg  <= wrData[3:0] & 4'b1011;
      if (ldLvt) begin
        lvtVec      <= wrData[VEC_W-1:0];
        lvtMask     <= wrData[LVT_MASK_BIT];
        lvtPeriodic <= wrData[LVT_PER_BIT];
      end
      if (ldInit)                      armed <= (wrData != '0);
      else if (expire && !lvtPeriodic) armed <= 1'b0;
      irqValid <= expire && !lvtMask;
      if (expire && !lvtMask) irqVector <= lvtVec;
    end
  end
endmodule

// File: rtl/cdt_dpath.sv
module cdt_dpath
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cdtStrb_t         strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initVal,
  input  logic [DIV_W-1:0] divShift,
  output logic             tick,
  output logic             cntZero,
  output logic [CNT_W-1:0] curCount
);
  localparam int PRE_W = (1 << DIV_W) - 1;
  localparam logic [DIV_W-1:0] RST_SHIFT = DIV_W'(1);

  logic [PRE_W-1:0] preCnt, preLim;
  logic [PRE_W:0]   span;
  logic [DIV_W-1:0] actShift;

  assign span    = {{PRE_W{1'b0}}, 1'b1} << actShift;
  assign preLim  = span[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
  assign tick    = (preCnt == preLim);
  assign cntZero = (curCount == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      actShift <= RST_SHIFT;
    end else if (strb.restart || tick) begin
      preCnt   <= '0;
      actShift <= divShift;
    end else begin
      preCnt   <= preCnt + {{(PRE_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             curCount <= '0;
    else if (strb.restart) curCount <= loadVal;
    else if (strb.reload)  curCount <= initVal;
    else if (strb.dec)     curCount <= curCount - {{(CNT_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  cdtStrb_t         strb;
  logic             tick, cntZero, lvtMask, lvtPeriodic;
  logic [CNT_W-1:0] initVal, curCount;
  logic [3:0]       divReg;
  logic [DIV_W-1:0] divShift;
  logic [VEC_W-1:0] lvtVec;

  cdt_ctrl #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tick(tick), .cntZero(cntZero), .strb(strb), .initVal(initVal),
    .divReg(divReg), .divShift(divShift), .lvtVec(lvtVec), .lvtMask(lvtMask),
    .lvtPeriodic(lvtPeriodic), .irqValid(irqValid), .irqVector(irqVector)
  );

  cdt_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(wrData), .initVal(initVal),
    .divShift(divShift), .tick(tick), .cntZero(cntZero), .curCount(curCount)
  );

  always_comb begin
    rdData = '0;
    unique case (regSel_e'(rdSel))
      SEL_INIT: rdData = initVal;
      SEL_DIV:  rdData[3:0] = divReg;
      SEL_LVT: begin
        rdData[LVT_PER_BIT]  = lvtPeriodic;
        rdData[LVT_MASK_BIT] = lvtMask;
        rdData[VEC_W-1:0]    = lvtVec;
      end
      default:  rdData = curCount;
    endcase
  end
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrSel,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] curCount,
  input logic [CNT_W-1:0] initVal,
  input logic             lvtMask,
  input logic             lvtPeriodic,
  input logic             irqValid
);
  // R7
  restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0) |=> (curCount == $past(wrData)));

  // R4
  count_down_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrSel == 2'd0) |=> (curCount <= $past(curCount)) || (curCount == initVal));

  // R4
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !lvtPeriodic && !(wrEn && wrSel == 2'd0)) |=> (curCount == '0));

  // R4
  fire_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ($past(curCount) == '0));

  // R6
  zero_start_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initVal == '0) |=> !irqValid);

  // R8
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvtMask |=> !irqValid);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |=> !irqValid);
endmodule

bind irq_countdown_timer cdt_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .curCount(curCount), .initVal(initVal), .lvtMask(lvtMask),
  .lvtPeriodic(lvtPeriodic), .irqValid(irqValid)
);

// File: tb/test_irq_countdown_timer.sv
module test_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = 2'd3;
  logic [31:0] rdData;
  logic        irqValid;
  logic [7:0]  irqVector;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_countdown_timer i_irq_countdown_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irqValid(irqValid), .irqVector(irqVector)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] s, input logic [31:0] d);
    wrSel = s; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rdSel = s; #1; v = rdData; rdSel = 2'd3; #1;
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(2'd0, v); chk(v == 32'h0, "R1 start value", v, 32'h0);
    rd(2'd1, v); chk(v == 32'h0, "R1 divider", v, 32'h0);
    rd(2'd2, v); chk(v == 32'h0001_0000, "R1 timer entry", v, 32'h0001_0000);
    rd(2'd3, v); chk(v == 32'h0, "R1 live count", v, 32'h0);
    chk(irqValid == 1'b0, "R1 no request", 32'(irqValid), 32'h0);
  endtask

  task automatic tOneShot();
    int fires = 0;
    wrReg(2'd1, 32'hB);
    wrReg(2'd2, 32'h0000_0040);
    wrReg(2'd0, 32'd3);
    chk(rdData == 32'd3, "R7 count loaded", rdData, 32'd3);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(rdData == ((k < 3) ? 32'(3 - k) : 32'd0), "R4 one-shot count", rdData, (k < 3) ? 32'(3 - k) : 32'd0);
      chk(irqValid == (k == 4), "R4 one-shot request timing", 32'(irqValid), 32'(k == 4));
      if (irqValid) begin
        fires++;
        chk(irqVector == 8'h40, "R9 vector", 32'(irqVector), 32'h40);
      end
    end
    chk(fires == 1, "R11 one request", 32'(fires), 32'd1);
  endtask

  task automatic tPeriodic();
    wrReg(2'd2, 32'h0002_0055);
    wrReg(2'd0, 32'd2);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk(rdData == 32'(2 - (k % 3)), "R5 repeat count", rdData, 32'(2 - (k % 3)));
      chk(irqValid == (k % 3 == 0), "R5 repeat request", 32'(irqValid), 32'(k % 3 == 0));
      if (irqValid) chk(irqVector == 8'h55, "R9 repeat vector", 32'(irqVector), 32'h55);
    end
  endtask

  task automatic tDivide();
    logic [31:0] v;
    wrReg(2'd1, 32'hF);
    rd(2'd1, v); chk(v == 32'hB, "R2 divider masked", v, 32'hB);
    wrReg(2'd1, 32'h1);
    wrReg(2'd2, 32'h0000_0021);
    wrReg(2'd0, 32'd2);
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      chk(rdData == 32'(2 - ((k / 4 > 2) ? 2 : k / 4)), "R2 divide by 4 count", rdData, 32'(2 - ((k / 4 > 2) ? 2 : k / 4)));
      chk(irqValid == (k == 12), "R2 divide by 4 request", 32'(irqValid), 32'(k == 12));
    end
    wrReg(2'd1, 32'h8);
    rd(2'd1, v); chk(v == 32'h8, "R2 divider readback", v, 32'h8);
    wrReg(2'd0, 32'd5);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k == 31) chk(rdData == 32'd5, "R2 divide by 32 before step", rdData, 32'd5);
      if (k == 32) chk(rdData == 32'd4, "R2 divide by 32 step", rdData, 32'd4);
    end
  endtask

  task automatic tDivChange();
    wrReg(2'd1, 32'h3);
    wrReg(2'd0, 32'd10);
    for (int k = 1; k <= 5; k++) @(negedge clk);
    wrReg(2'd1, 32'hB);
    for (int k = 7; k <= 17; k++) begin
      @(negedge clk);
      if (k == 15) chk(rdData == 32'd10, "R3 old interval kept", rdData, 32'd10);
      if (k == 16) chk(rdData == 32'd9, "R3 interval end", rdData, 32'd9);
      if (k == 17) chk(rdData == 32'd8, "R3 new divider used", rdData, 32'd8);
    end
  endtask

  task automatic tZero();
    int fires = 0;
    wrReg(2'd2, 32'h0002_0011);
    wrReg(2'd0, 32'd0);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (irqValid) fires++;
      chk(rdData == 32'd0, "R6 repeat zero count", rdData, 32'd0);
    end
    wrReg(2'd2, 32'h0000_0011);
    wrReg(2'd0, 32'd0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (irqValid) fires++;
    end
    chk(fires == 0, "R6 zero start never fires", 32'(fires), 32'd0);
  endtask

  task automatic tMask();
    int fires = 0;
    wrReg(2'd2, 32'h0001_0033);
    wrReg(2'd0, 32'd2);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (irqValid) fires++;
      if (k == 2) chk(rdData == 32'd0, "R8 counting while masked", rdData, 32'd0);
    end
    wrReg(2'd2, 32'h0000_0033);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (irqValid) fires++;
    end
    chk(fires == 0, "R8 masked one-shot silent", 32'(fires), 32'd0);
    wrReg(2'd2, 32'h0003_0033);
    wrReg(2'd0, 32'd1);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (irqValid) fires++;
    end
    chk(fires == 0, "R8 masked repeat silent", 32'(fires), 32'd0);
    wrReg(2'd2, 32'h0002_0033);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (irqValid) begin
        fires++;
        chk(irqVector == 8'h33, "R9 unmasked vector", 32'(irqVector), 32'h33);
      end
    end
    chk(fires == 3, "R8 repeat resumes after unmask", 32'(fires), 32'd3);
  endtask

  task automatic tCollide();
    logic [31:0] v;
    wrReg(2'd1, 32'hB);
    wrReg(2'd2, 32'h0000_0044);
    wrReg(2'd0, 32'd2);
    @(negedge clk); @(negedge clk);
    chk(rdData == 32'd0, "R4 reached zero", rdData, 32'd0);
    wrReg(2'd0, 32'd5);
    chk(rdData == 32'd5, "R7 restart value", rdData, 32'd5);
    chk(irqValid == 1'b0, "R7 collided expiry dropped", 32'(irqValid), 32'h0);
    for (int k = 4; k <= 9; k++) begin
      @(negedge clk);
      chk(irqValid == (k == 9), "R7 rearmed request", 32'(irqValid), 32'(k == 9));
    end
    wrReg(2'd3, 32'h77);
    chk(rdData == 32'd0, "R10 select 3 write ignored (count)", rdData, 32'd0);
    rd(2'd0, v); chk(v == 32'd5, "R10 select 3 write ignored (start)", v, 32'd5);
    wrReg(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk(v == 32'h0003_00FF, "R9 entry unused bits zero", v, 32'h0003_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tOneShot();
    tPeriodic();
    tDivide();
    tDivChange();
    tZero();
    tMask();
    tCollide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule